// File: doc/BRIEF.md
# Three-Wire Addressed Register Slave

This block is a slave on a shared three-wire control bus: a frame strobe, a bit clock and one open-drain data line with an external pull-up. The three pins are brought into the system clock domain through a synchronizer. A frame starts when the strobe falls. It carries a two-bit start code and a six-bit device identifier, followed by any number of records. Each record either writes one byte into a small register file or reads one byte back. A read turns the data line around, and the slave then pulls the line low for every 0 bit.

The register file holds the block control, clock mode and gain/oscillator settings. It also has a fixed identifier register and a soft-reset location. The three low bits of the block control register are decoded, together with an external slot-bar input, into an operating state. When the select input is low, the bus is switched off: the three bus pins act directly as the mode bits and the registers sit at their reset values.

Top module: `ctl3w_slave`

## Requirements
- R1: A strobe falling edge starts a frame and a high strobe ends it. A high strobe releases the data line. A clock falling edge seen while the strobe is high is ignored, and this holds even when the strobe rise and that clock fall reach the block in the same cycle.
- R2: The first eight bits of a frame are taken MSB first. They must read start code 01 followed by identifier 0x1F (byte 0x5F). Any other header makes the slave ignore the rest of the frame until the next strobe falling edge.
- R3: Bits are captured at the clock falling edge, after a two-flop synchronizer. A record is 18 bits long: a dummy bit, a direction bit (1 = write), a 7-bit address MSB first, a dummy bit, and 8 data bits MSB first. A write takes effect at the fall that captures the last data bit. Records repeat until the strobe rises.
- R4: In a record whose direction bit is 0, the slave drives the register value MSB first during the 8 data slots. It starts after the fall that captures the second dummy bit and shifts at each later fall. It pulls low only for 0 bits and releases the line after the fall of the last slot.
- R5: After reset, the block control register (address 0x04) is 0x3C, the clock mode register (0x09) is 0x0C and the gain/oscillator register (0x0C) is 0x0B.
- R6: Address 0x01 reads 0x1F, and writes to it have no effect.
- R7: A write of any value to address 0x00 restores all three registers to their reset values. A read of 0x00 returns 0x00.
- R8: Writes to any other address, including reserved 0x10 and 0x11, change nothing. Reads from those addresses return 0x00.
- R9: The operating state is decoded from the mode bits [2]=FM-bar, [1]=IDLE-bar and [0]=SLEEP-bar. If FM-bar is 0, the state is FM receive (1) when both SLEEP-bar and slot-bar are 1, and FM slot (0) otherwise. If FM-bar is 1, the state is CDMA sleep (2) when SLEEP-bar is 0, else CDMA idle (3) when IDLE-bar is 0, else CDMA receive (4).
- R10: With the select input low, the registers hold their reset values and the data line is released. The mode bits are taken from the synchronized pins: FM-bar from the data pin, IDLE-bar from the strobe pin and SLEEP-bar from the clock pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 1 = serial bus mode, 0 = direct pin mode control |
| strb_i | input | 1 | Frame strobe pin, or IDLE-bar in pin mode |
| sclk_i | input | 1 | Bit clock pin, or SLEEP-bar in pin mode |
| sdat_i | input | 1 | Level seen on the data line, or FM-bar in pin mode |
| slot_n_i | input | 1 | External slot-bar level used by the state decode |
| sdat_pull_o | output | 1 | Pull-down enable for the open-drain data line |
| ctl_reg_o | output | 8 | Block control register |
| clkmode_reg_o | output | 8 | Clock mode register |
| gain_reg_o | output | 8 | Gain/oscillator control register |
| op_state_o | output | 3 | Decoded operating state |

## Verification
The strobe rise and the clock fall that captures the last data bit of a write can reach the decoder in the same system cycle. The strobe must win, so the write must not happen. The bench provokes this by moving both pins at the same instant at the end of a write record. A behavioural model runs alongside and is compared every cycle. An explicit readback then confirms that the register kept its earlier value while a normal frame with the same record does commit.

// File: rtl/ctl3w_pkg.sv
`timescale 1ns/1ps
package ctl3w_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HDR  = 2'd1,
      PH_REC  = 2'd2,
      PH_IGN  = 2'd3
   } phase_t;

   typedef enum logic [2:0] {
      ST_FM_SLOT    = 3'd0,
      ST_FM_RX      = 3'd1,
      ST_CDMA_SLEEP = 3'd2,
      ST_CDMA_IDLE  = 3'd3,
      ST_CDMA_RX    = 3'd4
   } opstate_t;

   localparam logic [7:0] DEF_CTL  = 8'h3C;
   localparam logic [7:0] DEF_CLK  = 8'h0C;
   localparam logic [7:0] DEF_GAIN = 8'h0B;
endpackage

// File: rtl/ctl3w_sync.sv
`timescale 1ns/1ps
module ctl3w_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_d
);
   // chain[0] is the newest sample; one extra stage keeps the previous value
   logic [STAGES:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], d};
   end

   assign q   = chain[STAGES-1];
   assign q_d = chain[STAGES];
endmodule

// File: rtl/ctl3w_regs.sv
`timescale 1ns/1ps
module ctl3w_regs #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int ID_W   = 6,
   parameter logic [ID_W-1:0] DEV_ID = 6'h1F,
   parameter logic [ADDR_W-1:0] A_SRST = 7'h00,
   parameter logic [ADDR_W-1:0] A_ID   = 7'h01,
   parameter int NRW = 3,
   parameter logic [NRW*ADDR_W-1:0] RW_ADDRS = {7'h0C, 7'h09, 7'h04},
   parameter logic [NRW*DATA_W-1:0] RW_DEFS  = {8'h0B, 8'h0C, 8'h3C}
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_sel,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   output logic [NRW-1:0][DATA_W-1:0]   reg_q
);
   logic soft_rst;
   assign soft_rst = wr_en && (wr_addr == A_SRST);

   for (genvar i = 0; i < NRW; i++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_ADDR = RW_ADDRS[i*ADDR_W +: ADDR_W];
      localparam logic [DATA_W-1:0] MY_DEF  = RW_DEFS[i*DATA_W +: DATA_W];
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            r <= MY_DEF;
         else if (!bus_sel || soft_rst)         r <= MY_DEF;
         else if (wr_en && wr_addr == MY_ADDR)  r <= wr_data;
      end
      assign reg_q[i] = r;
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_ID) rd_data = {{(DATA_W-ID_W){1'b0}}, DEV_ID};
      for (int i = 0; i < NRW; i++)
         if (rd_addr == RW_ADDRS[i*ADDR_W +: ADDR_W]) rd_data = reg_q[i];
   end
endmodule

// File: rtl/ctl3w_frame.sv
`timescale 1ns/1ps
module ctl3w_frame
   import ctl3w_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int ID_W   = 6,
   parameter logic [ID_W-1:0] DEV_ID = 6'h1F,
   parameter logic [1:0] START_CODE = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              st,
   input  logic              st_d,
   input  logic              ck,
   input  logic              ck_d,
   input  logic              dat,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rec_addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              pull
);
   localparam int HDR_BITS = 2 + ID_W;
   localparam int REC_BITS = 2 + ADDR_W + 1 + DATA_W;
   localparam int CNT_W    = $clog2(REC_BITS);
   localparam logic [CNT_W-1:0] P_DIR   = CNT_W'(1);
   localparam logic [CNT_W-1:0] P_ALAST = CNT_W'(1 + ADDR_W);
   localparam logic [CNT_W-1:0] P_DUM2  = CNT_W'(2 + ADDR_W);
   localparam logic [CNT_W-1:0] P_LAST  = CNT_W'(REC_BITS - 1);
   localparam logic [CNT_W-1:0] P_HLAST = CNT_W'(HDR_BITS - 1);
   localparam logic [HDR_BITS-1:0] HDR_OK = {START_CODE, DEV_ID};

   phase_t              ph;
   logic [CNT_W-1:0]    cnt;
   logic [HDR_BITS-1:0] hsh;
   logic [DATA_W-1:0]   dsh, rsh;
   logic                dir, drv;
   logic                st_fall, ck_fall, bit_ev;

   assign st_fall = st_d & ~st;
   assign ck_fall = ck_d & ~ck;
   // a bit counts only when nothing of higher priority happens in the same cycle
   assign bit_ev  = bus_sel & ~st_fall & ~st & ck_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= PH_IDLE; cnt <= '0; hsh <= '0; dsh <= '0; rsh <= '0;
         dir <= 1'b0; drv <= 1'b0; rec_addr <= '0;
      end else if (!bus_sel) begin
         ph <= PH_IDLE; drv <= 1'b0;
      end else if (st_fall) begin
         ph <= PH_HDR; cnt <= '0; drv <= 1'b0;
      end else if (st) begin
         ph <= PH_IDLE; drv <= 1'b0;
      end else if (ck_fall) begin
         case (ph)
            PH_HDR: begin
               hsh <= {hsh[HDR_BITS-2:0], dat};
               if (cnt == P_HLAST) begin
                  ph  <= ({hsh[HDR_BITS-2:0], dat} == HDR_OK) ? PH_REC : PH_IGN;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_REC: begin
               dsh <= {dsh[DATA_W-2:0], dat};
               if (cnt == P_DIR) dir <= dat;
               if (cnt > P_DIR && cnt <= P_ALAST) rec_addr <= {rec_addr[ADDR_W-2:0], dat};
               if (cnt == P_DUM2 && !dir) begin
                  rsh <= rd_data;
                  drv <= 1'b1;
               end
               if (cnt > P_DUM2 && cnt < P_LAST) rsh <= {rsh[DATA_W-2:0], 1'b0};
               if (cnt == P_LAST) begin
                  drv <= 1'b0;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign wr_en   = bit_ev && (ph == PH_REC) && (cnt == P_LAST) && dir;
   assign wr_data = {dsh[DATA_W-2:0], dat};
   assign pull    = drv & ~rsh[DATA_W-1];
endmodule

// File: rtl/ctl3w_mode.sv
`timescale 1ns/1ps
module ctl3w_mode
   import ctl3w_pkg::*;
(
   input  logic       bus_sel,
   input  logic [2:0] reg_bits,
   input  logic [2:0] pin_bits,
   input  logic       slot_n,
   output logic [2:0] state
);
   logic [2:0] mb;
   opstate_t   s;
   assign mb = bus_sel ? reg_bits : pin_bits;

   always_comb begin
      if (!mb[2])      s = (mb[0] && slot_n) ? ST_FM_RX : ST_FM_SLOT;
      else if (!mb[0]) s = ST_CDMA_SLEEP;
      else if (!mb[1]) s = ST_CDMA_IDLE;
      else             s = ST_CDMA_RX;
   end
   assign state = s;
endmodule

// File: rtl/ctl3w_slave.sv
`timescale 1ns/1ps
module ctl3w_slave
   import ctl3w_pkg::*;
#(
   parameter int ID_W        = 6,
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [ID_W-1:0] DEV_ID     = 6'h1F,
   parameter logic [1:0]      START_CODE = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              strb_i,
   input  logic              sclk_i,
   input  logic              sdat_i,
   input  logic              slot_n_i,
   output logic              sdat_pull_o,
   output logic [DATA_W-1:0] ctl_reg_o,
   output logic [DATA_W-1:0] clkmode_reg_o,
   output logic [DATA_W-1:0] gain_reg_o,
   output logic [2:0]        op_state_o
);
   localparam int NRW = 3;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ctl3w_slave: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 3 || DATA_W < ID_W || ADDR_W < 5) begin : g_bad_width
      $error("ctl3w_slave: data or address width too small for the register map");
   end

   logic [2:0] pin_q, pin_qd;   // {strobe, clock, data}
   logic [ADDR_W-1:0] rec_addr;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic wr_en;
   logic [NRW-1:0][DATA_W-1:0] reg_q;

   ctl3w_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({strb_i, sclk_i, sdat_i}),
      .q(pin_q), .q_d(pin_qd)
   );

   ctl3w_frame #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
      .DEV_ID(DEV_ID), .START_CODE(START_CODE)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
      .st(pin_q[2]), .st_d(pin_qd[2]), .ck(pin_q[1]), .ck_d(pin_qd[1]),
      .dat(pin_q[0]), .rd_data(rd_data), .rec_addr(rec_addr),
      .wr_en(wr_en), .wr_data(wr_data), .pull(sdat_pull_o)
   );

   ctl3w_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .DEV_ID(DEV_ID),
      .A_SRST(ADDR_W'(0)), .A_ID(ADDR_W'(1)), .NRW(NRW),
      .RW_ADDRS({ADDR_W'(12), ADDR_W'(9), ADDR_W'(4)}),
      .RW_DEFS({DATA_W'(DEF_GAIN), DATA_W'(DEF_CLK), DATA_W'(DEF_CTL)})
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .wr_en(wr_en),
      .wr_addr(rec_addr), .wr_data(wr_data), .rd_addr(rec_addr),
      .rd_data(rd_data), .reg_q(reg_q)
   );

   assign ctl_reg_o     = reg_q[0];
   assign clkmode_reg_o = reg_q[1];
   assign gain_reg_o    = reg_q[2];

   ctl3w_mode u_mode (
      .bus_sel(bus_sel), .reg_bits(reg_q[0][2:0]),
      .pin_bits({pin_q[0], pin_q[2], pin_q[1]}),
      .slot_n(slot_n_i), .state(op_state_o)
   );
endmodule

// File: rtl/ctl3w_slave_chk.sv
`timescale 1ns/1ps
module ctl3w_slave_chk
   import ctl3w_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              strb_i,
   input logic              sclk_i,
   input logic              sdat_i,
   input logic              slot_n_i,
   input logic              sdat_pull_o,
   input logic [DATA_W-1:0] ctl_reg_o,
   input logic [DATA_W-1:0] clkmode_reg_o,
   input logic [DATA_W-1:0] gain_reg_o,
   input logic [2:0]        op_state_o
);
   p_released_in_pin_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> !sdat_pull_o);

   p_defaults_in_pin_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> (ctl_reg_o == DATA_W'(DEF_CTL) && clkmode_reg_o == DATA_W'(DEF_CLK)
                    && gain_reg_o == DATA_W'(DEF_GAIN)));

   p_fm_slot_when_all_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && ctl_reg_o[2:0] == 3'b000) |-> op_state_o == ST_FM_SLOT);

   p_fm_rx_follows_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && ctl_reg_o[2:0] == 3'b001 && slot_n_i) |-> op_state_o == ST_FM_RX);

   // the synchronized strobe lags the pin by three samples at the checker
   p_no_pull_after_strobe_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sdat_pull_o |-> (!$past(strb_i, 3) && $past(bus_sel)));

   p_regs_hold_while_strobe_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_sel) && $past(strb_i, 3)) |->
         ($stable(ctl_reg_o) && $stable(clkmode_reg_o) && $stable(gain_reg_o)));
endmodule

bind ctl3w_slave ctl3w_slave_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_ctl3w_slave.sv
`timescale 1ns/1ps
module sim_ctl3w_slave;
   localparam int H = 6;
   localparam int G = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, bus_sel, st_pin, ck_pin, m_low, slot_n;
   logic sdat_pull;
   logic [7:0] ctl_q, clk_q, gain_q;
   logic [2:0] state_q;
   wire  sdat_line = ~(m_low | sdat_pull);

   ctl3w_slave u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .strb_i(st_pin),
      .sclk_i(ck_pin), .sdat_i(sdat_line), .slot_n_i(slot_n),
      .sdat_pull_o(sdat_pull), .ctl_reg_o(ctl_q), .clkmode_reg_o(clk_q),
      .gain_reg_o(gain_q), .op_state_o(state_q)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // ---------------- behavioural reference ----------------
   logic [2:0] h1, h2, h3;   // pin samples {strobe, clock, data}, newest first
   int ph, cnt;
   logic [7:0] hsh, dsh, rsh, m_ctl, m_clk, m_gain;
   logic [6:0] ad;
   logic dir, drv;

   function automatic logic [7:0] m_read(input logic [6:0] a);
      case (a)
         7'd1:    return 8'h1F;
         7'd4:    return m_ctl;
         7'd9:    return m_clk;
         7'd12:   return m_gain;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [2:0] m_state(input logic fmn, input logic idn,
                                          input logic sln, input logic slot);
      if (fmn == 1'b0) return (sln && slot) ? 3'd1 : 3'd0;
      if (sln == 1'b0) return 3'd2;
      if (idn == 1'b0) return 3'd3;
      return 3'd4;
   endfunction

   task automatic m_defaults();
      m_ctl = 8'h3C; m_clk = 8'h0C; m_gain = 8'h0B;
   endtask

   always @(posedge clk) begin
      logic stf, ckf, b;
      if (!rst_n) begin
         h1 = '0; h2 = '0; h3 = '0; ph = 0; cnt = 0;
         hsh = '0; dsh = '0; rsh = '0; ad = '0; dir = 0; drv = 0;
         m_defaults();
      end else begin
         stf = h3[2] & ~h2[2];
         ckf = h3[1] & ~h2[1];
         b   = h2[0];
         if (!bus_sel) begin ph = 0; drv = 0; m_defaults(); end
         else if (stf) begin ph = 1; cnt = 0; drv = 0; end
         else if (h2[2]) begin ph = 0; drv = 0; end
         else if (ckf && ph == 1) begin
            hsh = {hsh[6:0], b};
            if (cnt == 7) begin ph = (hsh == 8'h5F) ? 2 : 3; cnt = 0; end
            else cnt++;
         end else if (ckf && ph == 2) begin
            dsh = {dsh[6:0], b};
            if (cnt == 1) dir = b;
            else if (cnt >= 2 && cnt <= 8) ad = {ad[5:0], b};
            else if (cnt == 9) begin
               if (!dir) begin rsh = m_read(ad); drv = 1; end
            end else if (cnt < 17) rsh = rsh << 1;
            if (cnt == 17) begin
               drv = 0;
               if (dir) begin
                  case (ad)
                     7'd0:  m_defaults();
                     7'd4:  m_ctl = dsh;
                     7'd9:  m_clk = dsh;
                     7'd12: m_gain = dsh;
                     default: ;
                  endcase
               end
               cnt = 0;
            end else cnt++;
         end
         h3 = h2; h2 = h1; h1 = {st_pin, ck_pin, sdat_line};
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [2:0] mb;
         n_cmp++;
         mb = bus_sel ? m_ctl[2:0] : {h2[0], h2[2], h2[1]};
         if (sdat_pull !== (drv & ~rsh[7])) begin
            n_bad++;
            $display("FAIL R4 t=%0t pull actual %0b expected %0b", $time, sdat_pull, drv & ~rsh[7]);
         end
         if ({ctl_q, clk_q, gain_q} !== {m_ctl, m_clk, m_gain}) begin
            n_bad++;
            $display("FAIL R3 t=%0t regs actual %h/%h/%h expected %h/%h/%h",
                     $time, ctl_q, clk_q, gain_q, m_ctl, m_clk, m_gain);
         end
         if (state_q !== m_state(mb[2], mb[1], mb[0], slot_n)) begin
            n_bad++;
            $display("FAIL R9 t=%0t state actual %0d expected %0d",
                     $time, state_q, m_state(mb[2], mb[1], mb[0], slot_n));
         end
      end
   end

   // ---------------- master side ----------------
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bit_tx(input logic b);
      m_low = ~b; tick(H); ck_pin = 1; tick(H); ck_pin = 0; tick(G);
   endtask

   task automatic frame_open(input logic [7:0] hdr);
      m_low = 0; ck_pin = 0; tick(H); st_pin = 0; tick(H);
      for (int i = 7; i >= 0; i--) bit_tx(hdr[i]);
   endtask

   task automatic frame_close();
      m_low = 0; tick(H); ck_pin = 1; tick(H); st_pin = 1; tick(2 * H);
   endtask

   task automatic rec_head(input logic wr, input logic [6:0] a);
      bit_tx(1'b1); bit_tx(wr);
      for (int i = 6; i >= 0; i--) bit_tx(a[i]);
      bit_tx(1'b1);
   endtask

   task automatic rec_write(input logic [6:0] a, input logic [7:0] d);
      rec_head(1'b1, a);
      for (int i = 7; i >= 0; i--) bit_tx(d[i]);
   endtask

   task automatic rec_read(input logic [6:0] a, output logic [7:0] v);
      rec_head(1'b0, a);
      v = '0;
      for (int i = 0; i < 8; i++) begin
         m_low = 0; tick(H); ck_pin = 1; tick(H);
         v = {v[6:0], sdat_line};
         ck_pin = 0; tick(G);
      end
   endtask

   task automatic wr1(input logic [6:0] a, input logic [7:0] d);
      frame_open(8'h5F); rec_write(a, d); frame_close();
   endtask

   task automatic rd1(input logic [6:0] a, output logic [7:0] v);
      frame_open(8'h5F); rec_read(a, v); frame_close();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      rst_n = 0; bus_sel = 1; st_pin = 1; ck_pin = 1; m_low = 0; slot_n = 1;
      tick(4); rst_n = 1; tick(4);

      // R5 reset values, R9 default decode (CDMA sleep)
      chk("R5 ctl reset", ctl_q, 8'h3C);
      chk("R5 clkmode reset", clk_q, 8'h0C);
      chk("R5 gain reset", gain_q, 8'h0B);
      chk("R4 line released after reset", sdat_pull, 0);
      chk("R9 default state", state_q, 2);

      // R3 single write and multi-record write
      wr1(7'h04, 8'h38);
      chk("R3 ctl write", ctl_q, 8'h38);
      chk("R9 bits 000 -> FM slot", state_q, 0);
      frame_open(8'h5F); rec_write(7'h09, 8'h55); rec_write(7'h0C, 8'hA3);
      rec_write(7'h04, 8'h01); frame_close();
      chk("R3 multi clkmode", clk_q, 8'h55);
      chk("R3 multi gain", gain_q, 8'hA3);
      chk("R9 bits 001 slot_n=1 -> FM rx", state_q, 1);
      slot_n = 0; tick(2);
      chk("R9 bits 001 slot_n=0 -> FM slot", state_q, 0);
      slot_n = 1;
      wr1(7'h04, 8'h05); chk("R9 bits 101 -> CDMA idle", state_q, 3);
      wr1(7'h04, 8'h07); chk("R9 bits 111 -> CDMA rx", state_q, 4);

      // R4 reads, R6 id, R8 unused and reserved, R7 read of soft reset
      frame_open(8'h5F);
      rec_read(7'h09, v); chk("R4 read clkmode", v, 8'h55);
      rec_read(7'h0C, v); chk("R4 read gain", v, 8'hA3);
      rec_read(7'h01, v); chk("R6 read id", v, 8'h1F);
      rec_read(7'h10, v); chk("R8 read reserved", v, 8'h00);
      rec_read(7'h00, v); chk("R7 read soft reset loc", v, 8'h00);
      frame_close();
      chk("R4 released after read frame", sdat_pull, 0);

      // R6 and R8 writes ignored
      frame_open(8'h5F); rec_write(7'h01, 8'h00); rec_write(7'h11, 8'hFF);
      rec_write(7'h7F, 8'h00); frame_close();
      rd1(7'h01, v); chk("R6 id after write", v, 8'h1F);
      chk("R8 ctl untouched", ctl_q, 8'h07);
      chk("R8 gain untouched", gain_q, 8'hA3);

      // R2 header faults
      frame_open(8'h5E); rec_write(7'h0C, 8'h11); frame_close();
      chk("R2 wrong id ignored", gain_q, 8'hA3);
      frame_open(8'hDF); rec_write(7'h0C, 8'h22); frame_close();
      chk("R2 bad start code ignored", gain_q, 8'hA3);

      // R1 strobe rise in the same cycle as the last data fall
      frame_open(8'h5F); rec_head(1'b1, 7'h0C);
      for (int i = 7; i >= 1; i--) bit_tx(1'b0);
      m_low = 0; tick(H); ck_pin = 1; tick(H); ck_pin = 0; st_pin = 1; tick(2 * H);
      ck_pin = 1; tick(H);
      chk("R1 cut write not committed", gain_q, 8'hA3);
      wr1(7'h0C, 8'h01);
      chk("R1 normal write after cut", gain_q, 8'h01);

      // R7 soft reset
      wr1(7'h00, 8'h5A);
      chk("R7 ctl restored", ctl_q, 8'h3C);
      chk("R7 clkmode restored", clk_q, 8'h0C);
      chk("R7 gain restored", gain_q, 8'h0B);

      // R10 pin mode
      wr1(7'h09, 8'hEE);
      bus_sel = 0; st_pin = 1; ck_pin = 1; m_low = 1; slot_n = 1; tick(6);
      chk("R10 regs default in pin mode", clk_q, 8'h0C);
      chk("R10 pins 0,1,1 slot=1 -> FM rx", state_q, 1);
      slot_n = 0; tick(6);
      chk("R10 pins slot=0 -> FM slot", state_q, 0);
      m_low = 0; st_pin = 0; ck_pin = 1; tick(6);
      chk("R10 pins 1,0,1 -> CDMA idle", state_q, 3);
      ck_pin = 0; tick(6);
      chk("R10 pins 1,0,0 -> CDMA sleep", state_q, 2);
      chk("R10 no pull in pin mode", sdat_pull, 0);
      st_pin = 1; ck_pin = 1; slot_n = 1; tick(6);
      bus_sel = 1; tick(6);
      rd1(7'h09, v); chk("R10 clkmode default back in bus mode", v, 8'h0C);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule